// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the configuration and output state of a 24-pin general-purpose I/O port. The pins are split into three byte-wide banks, and a simple byte bus reaches them. The bus has an address, a write strobe, write data and combinational read data. Pin n belongs to bank n/8 at bit n%8.

Each pin has three configuration bits: direction, drive type and pull. The block also keeps one output latch bit per pin. The latch is never written directly. Software raises latch bits through the set registers and lowers them through the clear registers. Raw pad inputs pass through a two-flop synchronizer and can be read back through read-only state registers.

The block decodes the configuration of each pin into pad controls: output enable, output value, open-drain select, pull enable, pull direction and input-buffer enable. Pins 16–19 and pins 20–23 each form a group of four. Each group is switched on by its own enable input. While a group is switched off, its pins are inert.

Top module: `gpio_port_regbank`

## Requirements
- R1: The direction registers are at 0x60, 0x61 and 0x63. The drive-type registers are at 0x64–0x66 and the pull registers at 0x68–0x6A. All of them read back the last value written to their enabled bits. Bit k of the register at offset b holds pin 8b+k.
- R2: Writes to the state registers at 0x10–0x12 change no register.
- R3: A write to a set register (0x6C–0x6E) sets the latch bit of each enabled pin whose data bit is 1. Latch bits written as 0 stay unchanged. Reading a set or clear register returns the latch byte.
- R4: A write to a clear register (0x70–0x72) clears the latch bit of each enabled pin whose data bit is 1. All other latch bits stay unchanged.
- R5: After reset every pin is an input, with type, pull and latch at 0. Every read returns 0x00 and every pad control output is 0.
- R6: An output pin (direction 1) with type 0 is push-pull. Its output enable is 1, its output value equals the latch, and it has no pull. An output pin with type 1 is open-drain: open-drain select is 1, output value is 0 and output enable equals the inverted latch. Its pull enable and pull-up both equal the pull bit. Output pins always have the input buffer on.
- R7: An input pin (direction 0) never has output enable. With type 1 its pull is enabled, and the pull direction follows the pull bit (1 means up, 0 means down). With type 0 there is no pull. The input buffer is then on when the pull bit is 1 (floating) and off when it is 0 (analog).
- R8: While a pin's group enable is 0, its bits read as 0 in every register and writes leave its stored bits unchanged. All of its pad control outputs are 0.
- R9: A pad input change becomes visible in the state registers after exactly two rising clock edges.
- R10: Unmapped addresses, 0x62 among them, read 0x00, and writes to them change no register.
- R11: A state register bit reads 0 when its pin's input buffer is off, whatever the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| alt_lo_en | input | 1 | Enables pins 16–19 |
| alt_hi_en | input | 1 | Enables pins 20–23 |
| pad_in | input | 24 | Raw pad input levels |
| pad_oe | output | 24 | Pad output enable |
| pad_out | output | 24 | Pad output value |
| pad_od | output | 24 | Open-drain select |
| pad_pull_en | output | 24 | Pull resistor enable |
| pad_pull_up | output | 24 | Pull direction, 1 means up |
| pad_ie | output | 24 | Input buffer enable |

## Verification
Several properties are checked on every cycle:
- a set write can only raise latch bits, and a clear write can only lower them;
- stored bits of disabled pins never move;
- writes to the state registers or to unmapped addresses leave all storage intact;
- open-drain pins never drive high, input pins never drive, and disabled pins have every pad control off.

Other behaviour only the bench's scenarios can show:
- the exact two-edge synchronizer delay;
- read-back values at each address;
- the decode tables for pull and input-buffer selection;
- the analog read-as-zero case.

The bench covers these with directed sequences and randomized traffic against its own register model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_IDX_W = 2;

  localparam int STATE_BASE = 'h10;
  localparam int DIR_BASE   = 'h60;
  localparam int TYPE_BASE  = 'h64;
  localparam int PULL_BASE  = 'h68;
  localparam int SET_BASE   = 'h6C;
  localparam int CLR_BASE   = 'h70;

  typedef enum logic [2:0] {
    K_NONE, K_STATE, K_DIR, K_TYPE, K_PULL, K_SET, K_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [BANK_IDX_W-1:0] bank;
  } reg_sel_t;

  typedef struct packed {
    logic oe;
    logic out;
    logic od;
    logic pull_en;
    logic pull_up;
    logic ie;
  } pad_ctl_t;

  // Direction bank 2 skips one address (0x62 stays unmapped).
  function automatic int dir_addr(input int b);
    return DIR_BASE + b + ((b >= 2) ? 1 : 0);
  endfunction

  function automatic reg_sel_t decode_addr(input logic [7:0] a, input int nb);
    reg_sel_t s;
    int       ai;
    s.kind = K_NONE;
    s.bank = '0;
    ai     = int'(a);
    for (int b = 0; b < nb; b++) begin
      if (ai == STATE_BASE + b)     begin s.kind = K_STATE; s.bank = BANK_IDX_W'(b); end
      if (ai == dir_addr(b))        begin s.kind = K_DIR;   s.bank = BANK_IDX_W'(b); end
      if (ai == TYPE_BASE + b)      begin s.kind = K_TYPE;  s.bank = BANK_IDX_W'(b); end
      if (ai == PULL_BASE + b)      begin s.kind = K_PULL;  s.bank = BANK_IDX_W'(b); end
      if (ai == SET_BASE + b)       begin s.kind = K_SET;   s.bank = BANK_IDX_W'(b); end
      if (ai == CLR_BASE + b)       begin s.kind = K_CLR;   s.bank = BANK_IDX_W'(b); end
    end
    return s;
  endfunction

  // Per-pin pad control: the meaning of type/pull depends on direction.
  function automatic pad_ctl_t pad_decode(input logic en, input logic dir,
                                          input logic typ, input logic pull,
                                          input logic lat);
    pad_ctl_t c;
    c = '0;
    if (en) begin
      if (dir) begin
        c.ie = 1'b1;
        if (!typ) begin
          c.oe  = 1'b1;
          c.out = lat;
        end else begin
          c.od      = 1'b1;
          c.oe      = ~lat;
          c.pull_en = pull;
          c.pull_up = pull;
        end
      end else begin
        if (typ) begin
          c.pull_en = 1'b1;
          c.pull_up = pull;
          c.ie      = 1'b1;
        end else begin
          c.ie = pull;
        end
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= raw_in;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] pin_en,
  input  logic [BANK_W-1:0] wdata,
  input  logic              wr_dir,
  input  logic              wr_type,
  input  logic              wr_pull,
  input  logic              wr_set,
  input  logic              wr_clr,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] type_q,
  output logic [BANK_W-1:0] pull_q,
  output logic [BANK_W-1:0] lat_q
);

  function automatic logic [BANK_W-1:0] merge_bits(input logic [BANK_W-1:0] old_v,
                                                   input logic [BANK_W-1:0] new_v,
                                                   input logic [BANK_W-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  logic [BANK_W-1:0] hit_ones;
  assign hit_ones = wdata & pin_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      type_q <= '0;
      pull_q <= '0;
      lat_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= merge_bits(dir_q,  wdata, pin_en);
      if (wr_type) type_q <= merge_bits(type_q, wdata, pin_en);
      if (wr_pull) pull_q <= merge_bits(pull_q, wdata, pin_en);
      if (wr_set)      lat_q <= lat_q | hit_ones;
      else if (wr_clr) lat_q <= lat_q & ~hit_ones;
    end
  end

  assert_set_only_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  assert_clr_only_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((lat_q & ~$past(lat_q)) == '0));

  assert_locked_bits_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en != '1) |=> ((((dir_q ^ $past(dir_q)) | (type_q ^ $past(type_q)) |
                          (pull_q ^ $past(pull_q)) | (lat_q ^ $past(lat_q)))
                         & ~$past(pin_en)) == '0));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_en,
  input  logic [NPINS-1:0] dir_v,
  input  logic [NPINS-1:0] type_v,
  input  logic [NPINS-1:0] pull_v,
  input  logic [NPINS-1:0] lat_v,
  output logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] out,
  output logic [NPINS-1:0] od,
  output logic [NPINS-1:0] pull_en,
  output logic [NPINS-1:0] pull_up,
  output logic [NPINS-1:0] ie
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pad_ctl_t ctl;
    assign ctl        = pad_decode(pin_en[i], dir_v[i], type_v[i], pull_v[i], lat_v[i]);
    assign oe[i]      = ctl.oe;
    assign out[i]     = ctl.out;
    assign od[i]      = ctl.od;
    assign pull_en[i] = ctl.pull_en;
    assign pull_up[i] = ctl.pull_up;
    assign ie[i]      = ctl.ie;

    assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      od[i] |-> (!out[i] && (oe[i] == !lat_v[i])));

    assert_input_never_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_v[i] |-> (!oe[i] && !od[i]));

    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en[i] |-> !(oe[i] || out[i] || od[i] || pull_en[i] || pull_up[i] || ie[i]));
  end

endmodule

// File: rtl/gpio_port_regbank.sv
module gpio_port_regbank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ALT_BASE    = 16,
  parameter int ALT_GRP     = 4,
  localparam int NPINS      = NUM_BANKS * BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             alt_lo_en,
  input  logic             alt_hi_en,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_od,
  output logic [NPINS-1:0] pad_pull_en,
  output logic [NPINS-1:0] pad_pull_up,
  output logic [NPINS-1:0] pad_ie
);

  reg_sel_t sel;
  assign sel = decode_addr(bus_addr, NUM_BANKS);

  logic wr_unmapped, wr_state;
  assign wr_unmapped = bus_wr && (sel.kind == K_NONE);
  assign wr_state    = bus_wr && (sel.kind == K_STATE);

  logic [NPINS-1:0] pin_en;
  for (genvar i = 0; i < NPINS; i++) begin : g_en
    if (i < ALT_BASE)                assign pin_en[i] = 1'b1;
    else if (i < ALT_BASE + ALT_GRP) assign pin_en[i] = alt_lo_en;
    else                             assign pin_en[i] = alt_hi_en;
  end

  logic [NUM_BANKS-1:0][BANK_W-1:0] en_b, dir_b, type_b, pull_b, lat_b, vis_b;
  logic [NPINS-1:0] sync_q;

  assign en_b = pin_en;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && (sel.bank == BANK_IDX_W'(b));
    gpio_cfg_bank #(.BANK_W(BANK_W)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_en  (en_b[b]),
      .wdata   (bus_wdata),
      .wr_dir  (hit && sel.kind == K_DIR),
      .wr_type (hit && sel.kind == K_TYPE),
      .wr_pull (hit && sel.kind == K_PULL),
      .wr_set  (hit && sel.kind == K_SET),
      .wr_clr  (hit && sel.kind == K_CLR),
      .dir_q   (dir_b[b]),
      .type_q  (type_b[b]),
      .pull_q  (pull_b[b]),
      .lat_q   (lat_b[b])
    );
  end

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (sync_q)
  );

  gpio_pad_ctrl #(.NPINS(NPINS)) pad_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_en  (pin_en),
    .dir_v   (dir_b),
    .type_v  (type_b),
    .pull_v  (pull_b),
    .lat_v   (lat_b),
    .oe      (pad_oe),
    .out     (pad_out),
    .od      (pad_od),
    .pull_en (pad_pull_en),
    .pull_up (pad_pull_up),
    .ie      (pad_ie)
  );

  // State is only visible where the input buffer is on (covers disabled pins too).
  assign vis_b = sync_q & pad_ie;

  always_comb begin
    unique case (sel.kind)
      K_STATE:      bus_rdata = vis_b[sel.bank];
      K_DIR:        bus_rdata = dir_b[sel.bank]  & en_b[sel.bank];
      K_TYPE:       bus_rdata = type_b[sel.bank] & en_b[sel.bank];
      K_PULL:       bus_rdata = pull_b[sel.bank] & en_b[sel.bank];
      K_SET, K_CLR: bus_rdata = lat_b[sel.bank]  & en_b[sel.bank];
      default:      bus_rdata = 8'h00;
    endcase
  end

  assert_unmapped_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(dir_b) && $stable(type_b) && $stable(pull_b) && $stable(lat_b)));

  assert_state_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_state |=> ($stable(dir_b) && $stable(type_b) && $stable(pull_b) && $stable(lat_b)));

endmodule

// File: tb/gpio_port_regbank_tb.sv
`timescale 1ns/1ps
module gpio_port_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        alt_lo_en = 1'b0;
  logic        alt_hi_en = 1'b0;
  logic [23:0] pad_in = '0;
  logic [23:0] pad_oe, pad_out, pad_od, pad_pull_en, pad_pull_up, pad_ie;

  always #5 clk = ~clk;

  gpio_port_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_lo_en(alt_lo_en),
    .alt_hi_en(alt_hi_en), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_od(pad_od), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_ie(pad_ie)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [23:0] m_dir = '0, m_type = '0, m_pull = '0, m_lat = '0, m_s1 = '0, m_s2 = '0;

  function automatic logic [23:0] en_vec(input logic lo, input logic hi);
    return {{4{hi}}, {4{lo}}, 16'hFFFF};
  endfunction

  // returns {kind, bank}: kind 0 none,1 state,2 dir,3 type,4 pull,5 set,6 clr
  function automatic logic [7:0] classify(input logic [7:0] a);
    if (a >= 8'h10 && a <= 8'h12) return {4'd1, 4'(a - 8'h10)};
    if (a == 8'h60 || a == 8'h61) return {4'd2, 4'(a - 8'h60)};
    if (a == 8'h63)               return {4'd2, 4'd2};
    if (a >= 8'h64 && a <= 8'h66) return {4'd3, 4'(a - 8'h64)};
    if (a >= 8'h68 && a <= 8'h6A) return {4'd4, 4'(a - 8'h68)};
    if (a >= 8'h6C && a <= 8'h6E) return {4'd5, 4'(a - 8'h6C)};
    if (a >= 8'h70 && a <= 8'h72) return {4'd6, 4'(a - 8'h70)};
    return 8'h00;
  endfunction

  // {oe,out,od,pull_en,pull_up,ie} for one pin, from the R6/R7/R8 tables
  function automatic logic [5:0] exp_pad(input int n, input logic [23:0] en);
    logic e, d, t, p, l;
    e = en[n]; d = m_dir[n]; t = m_type[n]; p = m_pull[n]; l = m_lat[n];
    return { e & d & (~t | ~l),
             e & d & ~t & l,
             e & d & t,
             e & t & (d ? p : 1'b1),
             e & t & p,
             e & (d | t | p) };
  endfunction

  function automatic logic [23:0] exp_ie_vec(input logic [23:0] en);
    logic [23:0] v;
    for (int n = 0; n < 24; n++) v[n] = exp_pad(n, en)[0];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [23:0] en);
    logic [7:0]  c;
    logic [23:0] src;
    c = classify(a);
    case (c[7:4])
      4'd1:      src = m_s2 & exp_ie_vec(en);
      4'd2:      src = m_dir & en;
      4'd3:      src = m_type & en;
      4'd4:      src = m_pull & en;
      4'd5, 4'd6: src = m_lat & en;
      default:   return 8'h00;
    endcase
    return src[int'(c[3:0])*8 +: 8];
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (classify(a) >> 4)
      8'd1: return "R9,R11";
      8'd2, 8'd3, 8'd4: return "R1";
      8'd5: return "R3";
      8'd6: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check_pads(input string tag);
    logic [23:0] en;
    logic [23:0] e_oe, e_out, e_od, e_pe, e_pu, e_ie;
    en = en_vec(alt_lo_en, alt_hi_en);
    for (int n = 0; n < 24; n++) begin
      {e_oe[n], e_out[n], e_od[n], e_pe[n], e_pu[n], e_ie[n]} = exp_pad(n, en);
    end
    checks++;
    if ({pad_oe, pad_out, pad_od, pad_pull_en, pad_pull_up, pad_ie} !==
        {e_oe, e_out, e_od, e_pe, e_pu, e_ie}) begin
      fails++;
      $display("FAIL %s pads oe/out/od/pe/pu/ie got %h %h %h %h %h %h exp %h %h %h %h %h %h",
               tag, pad_oe, pad_out, pad_od, pad_pull_en, pad_pull_up, pad_ie,
               e_oe, e_out, e_od, e_pe, e_pu, e_ie);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, check 1 ns after.
  task automatic cycle(input logic wr, input logic [7:0] a, input logic [7:0] d,
                       input logic [23:0] pins, input logic lo, input logic hi,
                       input string tag);
    logic [23:0] en, wm;
    logic [7:0]  c;
    logic [7:0]  exp;
    string       t;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; pad_in = pins;
    alt_lo_en = lo; alt_hi_en = hi;
    @(posedge clk);
    en = en_vec(lo, hi);
    c  = classify(a);
    wm = 24'(d) << (int'(c[3:0]) * 8);
    wm = wm & en;
    if (wr) begin
      case (c[7:4])
        4'd2: m_dir  = (m_dir  & ~wm) | wm;
        4'd3: m_type = (m_type & ~wm) | wm;
        4'd4: m_pull = (m_pull & ~wm) | wm;
        4'd5: m_lat  = m_lat | wm;
        4'd6: m_lat  = m_lat & ~wm;
        default: ;
      endcase
      // clear bits in the targeted byte that were written as 0
      if (c[7:4] == 4'd2) m_dir  = m_dir  & ~((~(24'(d) << (int'(c[3:0])*8))) & (24'hFF << (int'(c[3:0])*8)) & en);
      if (c[7:4] == 4'd3) m_type = m_type & ~((~(24'(d) << (int'(c[3:0])*8))) & (24'hFF << (int'(c[3:0])*8)) & en);
      if (c[7:4] == 4'd4) m_pull = m_pull & ~((~(24'(d) << (int'(c[3:0])*8))) & (24'hFF << (int'(c[3:0])*8)) & en);
    end
    m_s2 = m_s1;
    m_s1 = pins;
    #1;
    t   = (tag == "") ? tag_of(a) : tag;
    exp = exp_read(a, en);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %h got %h exp %h", t, a, bus_rdata, exp);
    end
    check_pads("R6,R7,R8");
  endtask

  task automatic read_all(input logic [23:0] pins, input logic lo, input logic hi,
                          input string tag);
    logic [7:0] addrs [15] = '{8'h10, 8'h11, 8'h12, 8'h60, 8'h61, 8'h63, 8'h64,
                               8'h65, 8'h66, 8'h68, 8'h69, 8'h6A, 8'h6C, 8'h6D, 8'h70};
    for (int i = 0; i < 15; i++) cycle(1'b0, addrs[i], 8'h00, pins, lo, hi, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [20] = '{8'h10, 8'h11, 8'h12, 8'h60, 8'h61, 8'h63, 8'h64, 8'h65,
                              8'h66, 8'h68, 8'h69, 8'h6A, 8'h6C, 8'h6D, 8'h6E, 8'h70,
                              8'h71, 8'h72, 8'h62, 8'hFF};
    logic lo, hi;
    void'($urandom(32'h5EED1234));
    pad_in = 24'hFFFFFF;
    repeat (3) @(posedge clk);
    #1;
    // R5: reset state, with pads high to show analog inputs read 0
    checks++;
    if (bus_rdata !== 8'h00) begin
      fails++;
      $display("FAIL R5 reset read got %h exp 00", bus_rdata);
    end
    check_pads("R5");
    @(negedge clk);
    rst_n = 1'b1;
    m_s1 = 24'hFFFFFF;
    read_all(24'hFFFFFF, 1'b1, 1'b1, "R5");

    // R1: configuration read-back
    cycle(1, 8'h60, 8'hA5, '0, 1, 1, "R1");
    cycle(0, 8'h60, 8'h00, '0, 1, 1, "R1");
    cycle(1, 8'h65, 8'h3C, '0, 1, 1, "R1");
    cycle(1, 8'h6A, 8'h81, '0, 1, 1, "R1");
    cycle(0, 8'h65, 8'h00, '0, 1, 1, "R1");

    // R3/R4: set and clear only touch ones
    cycle(1, 8'h6C, 8'h0F, '0, 1, 1, "R3");
    cycle(1, 8'h6C, 8'h30, '0, 1, 1, "R3");
    cycle(0, 8'h70, 8'h00, '0, 1, 1, "R3");
    cycle(1, 8'h70, 8'h05, '0, 1, 1, "R4");
    cycle(0, 8'h6C, 8'h00, '0, 1, 1, "R4");

    // R6: output pins push-pull vs open-drain
    cycle(1, 8'h61, 8'hFF, '0, 1, 1, "R6");
    cycle(1, 8'h6D, 8'h55, '0, 1, 1, "R6");
    cycle(1, 8'h65, 8'hF0, '0, 1, 1, "R6");
    cycle(1, 8'h69, 8'hCC, '0, 1, 1, "R6");

    // R2: state writes ignored
    cycle(1, 8'h10, 8'hFF, '0, 1, 1, "R2");
    cycle(1, 8'h11, 8'hFF, '0, 1, 1, "R2");
    read_all('0, 1, 1, "R2");

    // R7/R9/R11: pin 0 input pull-up, pin 1 analog
    cycle(1, 8'h60, 8'h00, '0, 1, 1, "R7");
    cycle(1, 8'h64, 8'h01, '0, 1, 1, "R7");
    cycle(1, 8'h68, 8'h01, '0, 1, 1, "R7");
    cycle(0, 8'h10, 8'h00, '0, 1, 1, "R9");
    cycle(0, 8'h10, 8'h00, '0, 1, 1, "R9");
    cycle(0, 8'h10, 8'h00, 24'h000003, 1, 1, "R9");
    cycle(0, 8'h10, 8'h00, 24'h000003, 1, 1, "R9");
    cycle(0, 8'h10, 8'h00, 24'h000003, 1, 1, "R11");
    cycle(0, 8'h10, 8'h00, 24'h000000, 1, 1, "R9");
    cycle(0, 8'h10, 8'h00, 24'h000000, 1, 1, "R9");

    // R8: groups disabled
    cycle(1, 8'h63, 8'hFF, '0, 0, 0, "R8");
    cycle(1, 8'h6E, 8'hFF, '0, 0, 0, "R8");
    cycle(0, 8'h63, 8'h00, '0, 1, 1, "R8");
    cycle(1, 8'h63, 8'hFF, '0, 1, 0, "R8");
    cycle(0, 8'h63, 8'h00, '0, 1, 1, "R8");
    cycle(1, 8'h6E, 8'hFF, '0, 0, 1, "R8");
    cycle(0, 8'h6E, 8'h00, '0, 1, 1, "R8");

    // R10: unmapped addresses, including the gap in the direction bank
    cycle(1, 8'h62, 8'hFF, '0, 1, 1, "R10");
    cycle(0, 8'h63, 8'h00, '0, 1, 1, "R10");
    cycle(1, 8'h13, 8'hFF, '0, 1, 1, "R10");
    cycle(1, 8'h00, 8'hFF, '0, 1, 1, "R10");
    read_all('0, 1, 1, "R10");

    // Constrained random traffic
    lo = 1; hi = 1;
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 64) == 0) begin
        lo = 1'($urandom);
        hi = 1'($urandom);
      end
      cycle(1'($urandom % 3 != 0), pool[$urandom % 20], 8'($urandom),
            24'($urandom), lo, hi, "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule